// File: doc/BRIEF.md
# Event-to-Task Channel Interconnect

This block lets peripherals trigger one another without software. Event sources produce single-cycle pulses. Task sinks accept single-cycle pulses. Between them sits a set of numbered channels. Each source has a link register that names the channel it drives. Each sink has a link register that names the channel it listens to. A channel passes pulses only while its enable bit is set.

Because routing goes through channels rather than fixed wires, one event can reach many tasks. Several events can also share one channel, where they are ORed. Any mix of the two is possible.

Software configures the block through a single-cycle register write port. That port writes the whole channel-enable mask, or sets or clears selected enable bits in one write. Sources, sinks and configuration all share one clock. An event reaches its tasks exactly one clock later.

Top module: `evt_task_ic`

## Requirements
- R1: After reset every task output is 0, every channel is disabled and every source and sink link is switched off.
- R2: An event pulse sampled at clock edge t on a source linked to an enabled channel produces a task pulse at edge t+1 on each sink linked to that channel. That task pulse lasts one cycle when the event lasts one cycle.
- R3: One event fans out to every sink subscribed to its channel, and separate channels carry pulses at the same time without affecting each other.
- R4: Events from several sources published to one channel are ORed: simultaneous events give one task pulse, and events in different cycles give a pulse for each.
- R5: A disabled channel passes no pulse to any sink.
- R6: A link register holds a channel number in bits [7:0] and a link-on bit in bit 31. A link whose bit 31 is 0 neither drives nor receives any channel.
- R7: The channel field addresses a global space of 0 to 255. Of that space, local channels 0 to 15 exist. A link naming channel 16 or above connects to nothing, and channel 15 works normally.
- R8: Word addresses are fixed as follows. 0x00 writes the whole enable mask (bit c enables channel c). 0x01 is write-one-to-set and 0x02 is write-one-to-clear. 0x10+i is the link register of source i and 0x20+j is the link register of sink j. Zero bits written to 0x01 or 0x02 leave their channels unchanged, and the mask changes only on a write.
- R9: A write of ones to the set address enables exactly those channels. A write of ones to the clear address disables exactly those channels.
- R10: An event that arrives in the same cycle as a write that disables or enables its channel is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | N_EVT | Event pulses, one bit per source |
| task_o | output | N_TSK | Task pulses, one bit per sink |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
Some properties are checked on every cycle:
- A task pulse is always preceded by an event one cycle earlier and by a nonzero enable mask.
- The set and clear writes force exactly the written bits.
- Zero-data writes and idle cycles leave the mask unchanged.

Other behaviour can only be shown by the bench's scenarios:
- Routing correctness: fan-out, OR-merging, and links switched off or pointing beyond channel 15.
- The dropping of events that coincide with an enable change.

A reference model in the bench predicts each cycle's task vector for these scenarios.

// File: rtl/evt_ic_pkg.sv
// Package: shared constants and types for the event-to-task interconnect.
// Assumes a single configuration write port with word addressing.
package evt_ic_pkg;
    localparam int CFG_AW      = 8;
    localparam int CFG_DW      = 32;
    localparam int CH_FIELD_W  = 8;   // global channel index 0..255
    localparam int LINK_ON_BIT = 31;

    localparam logic [CFG_AW-1:0] ADDR_CH_MASK = 8'h00;
    localparam logic [CFG_AW-1:0] ADDR_CH_SET  = 8'h01;
    localparam logic [CFG_AW-1:0] ADDR_CH_CLR  = 8'h02;
    localparam int                ADDR_SRC_BASE = 'h10;
    localparam int                ADDR_SNK_BASE = 'h20;

    typedef struct packed {
        logic                  on;
        logic [CH_FIELD_W-1:0] ch;
    } link_cfg_t;
endpackage

// File: rtl/ic_chan_ctrl.sv
// Channel controller: holds one enable bit per local channel.
// Writes can replace the whole mask, set bits, or clear bits.
// Exposes the current mask and the value it takes at the next edge.
// Assumes N_CH <= CFG_DW.
module ic_chan_ctrl
    import evt_ic_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [N_CH-1:0]   en_q,
    output logic [N_CH-1:0]   en_d
);
    logic [N_CH-1:0] wmask;
    assign wmask = cfg_wdata[N_CH-1:0];

    // Next mask value from the current write, if any.
    always_comb begin
        en_d = en_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_CH_MASK: en_d = wmask;
                ADDR_CH_SET:  en_d = en_q | wmask;
                ADDR_CH_CLR:  en_d = en_q & ~wmask;
                default:      en_d = en_q;
            endcase
        end
    end

    // Mask register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end
endmodule

// File: rtl/ic_link_regs.sv
// Link register bank: one register per port (source or sink).
// Each register holds a channel number and a link-on bit, and is decoded
// into a one-hot (or empty) local-channel select per port.
// Channel numbers at or beyond N_CH select nothing.
// Assumes the port's address range does not overlap other registers.
module ic_link_regs
    import evt_ic_pkg::*;
#(
    parameter int N_PORT = 4,
    parameter int N_CH   = 16,
    parameter int BASE   = 'h10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [CFG_DW-1:0]            cfg_wdata,
    output logic [N_PORT-1:0][N_CH-1:0]  sel_o
);
    for (genvar k = 0; k < N_PORT; k++) begin : g_port
        link_cfg_t cfg_q;
        logic      hit;
        assign hit = cfg_we && (cfg_addr == CFG_AW'(BASE + k));

        // Store this port's link register on an address hit.
        always_ff @(posedge clk) begin
            if (!rst_n)   cfg_q <= '0;
            else if (hit) cfg_q <= '{on: cfg_wdata[LINK_ON_BIT],
                                     ch: cfg_wdata[CH_FIELD_W-1:0]};
        end

        for (genvar c = 0; c < N_CH; c++) begin : g_dec
            assign sel_o[k][c] = cfg_q.on && (cfg_q.ch == CH_FIELD_W'(c));
        end
    end
endmodule

// File: rtl/ic_route.sv
// Routing core: merges published events per channel (OR), gates them
// by the channel enable, and fans them out to subscribed sinks through
// one output register.
// Assumes pub_sel/sub_sel each hold at most one bit per port.
module ic_route #(
    parameter int N_EVT = 4,
    parameter int N_TSK = 4,
    parameter int N_CH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_EVT-1:0]           evt_i,
    input  logic [N_EVT-1:0][N_CH-1:0] pub_sel,
    input  logic [N_TSK-1:0][N_CH-1:0] sub_sel,
    input  logic [N_CH-1:0]            gate,
    output logic [N_TSK-1:0]           task_o
);
    logic [N_CH-1:0]  ch_fire;
    logic [N_TSK-1:0] task_d;

    // Per-channel OR of published events, masked by the channel gate.
    always_comb begin
        ch_fire = '0;
        for (int c = 0; c < N_CH; c++) begin
            for (int i = 0; i < N_EVT; i++) begin
                ch_fire[c] = ch_fire[c] | (evt_i[i] & pub_sel[i][c]);
            end
        end
        ch_fire = ch_fire & gate;
    end

    // Each sink fires when its subscribed channel fires.
    always_comb begin
        for (int j = 0; j < N_TSK; j++) begin
            task_d[j] = |(ch_fire & sub_sel[j]);
        end
    end

    // Single register stage gives a fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) task_o <= '0;
        else        task_o <= task_d;
    end
endmodule

// File: rtl/evt_task_ic.sv
// Top: event-to-task channel interconnect.
// Sources publish to a channel, sinks subscribe to a channel, and the
// controller gates each channel. A channel passes an event only when it
// is enabled both before and after the current write. An event therefore
// coinciding with an enable change is dropped.
// Assumes N_CH <= 32 and N_EVT, N_TSK <= 16 (no address overlap).
module evt_task_ic
    import evt_ic_pkg::*;
#(
    parameter int N_EVT = 4,
    parameter int N_TSK = 4,
    parameter int N_CH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    output logic [N_TSK-1:0]  task_o,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata
);
    logic [N_CH-1:0]            ch_en_q;
    logic [N_CH-1:0]            ch_en_d;
    logic [N_CH-1:0]            ch_gate;
    logic [N_EVT-1:0][N_CH-1:0] pub_sel;
    logic [N_TSK-1:0][N_CH-1:0] sub_sel;

    ic_chan_ctrl #(.N_CH(N_CH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .en_q(ch_en_q), .en_d(ch_en_d)
    );

    ic_link_regs #(.N_PORT(N_EVT), .N_CH(N_CH), .BASE(ADDR_SRC_BASE)) u_pub (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sel_o(pub_sel)
    );

    ic_link_regs #(.N_PORT(N_TSK), .N_CH(N_CH), .BASE(ADDR_SNK_BASE)) u_sub (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sel_o(sub_sel)
    );

    // Gate open only if enabled now and staying enabled.
    assign ch_gate = ch_en_q & ch_en_d;

    ic_route #(.N_EVT(N_EVT), .N_TSK(N_TSK), .N_CH(N_CH)) u_route (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pub_sel(pub_sel),
        .sub_sel(sub_sel), .gate(ch_gate), .task_o(task_o)
    );
endmodule

// File: rtl/evt_task_ic_chk.sv
// Checker: temporal properties of the interconnect, bound to the top.
// Assumes it sees the top's ports and its channel-enable register.
module evt_task_ic_chk
    import evt_ic_pkg::*;
#(
    parameter int N_EVT = 4,
    parameter int N_TSK = 4,
    parameter int N_CH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_EVT-1:0]  evt_i,
    input logic [N_TSK-1:0]  task_o,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_wdata,
    input logic [N_CH-1:0]   ch_en
);
    logic [N_CH-1:0] wm;
    assign wm = cfg_wdata[N_CH-1:0];

    assert_task_follows_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|task_o) |-> $past(|evt_i));

    assert_task_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|task_o) |-> ($past(ch_en) != '0));

    assert_set_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_CH_SET) |=> ((ch_en & $past(wm)) == $past(wm)));

    assert_clr_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_CH_CLR) |=> ((ch_en & $past(wm)) == '0));

    assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr == ADDR_CH_SET || cfg_addr == ADDR_CH_CLR) && wm == '0)
        |=> $stable(ch_en));

    assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ch_en));
endmodule

bind evt_task_ic evt_task_ic_chk #(.N_EVT(N_EVT), .N_TSK(N_TSK), .N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .task_o(task_o), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ch_en(ch_en_q)
);

// File: tb/tb_evt_task_ic.sv
// Scoreboard bench: the driver computes each cycle's expected task vector
// from a requirement-level model and queues it; the monitor compares
// on the falling edge after the design's output register updates.
module tb_evt_task_ic;
    localparam int NE = 4;
    localparam int NT = 4;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_i = '0;
    logic [NT-1:0] task_o;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;

    evt_task_ic #(.N_EVT(NE), .N_TSK(NT), .N_CH(NC)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .task_o(task_o),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        int            due;
        logic [NT-1:0] exp;
        int            req;
    } sb_t;
    sb_t sb[$];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Model state
    logic [NC-1:0] m_en = '0;
    logic [31:0]   m_pub [NE];
    logic [31:0]   m_sub [NT];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NT-1:0] model(input logic [NE-1:0] ev,
                                            input logic [NC-1:0] e_old,
                                            input logic [NC-1:0] e_new);
        logic [NT-1:0] r = '0;
        for (int j = 0; j < NT; j++) begin
            if (m_sub[j][31] && m_sub[j][7:0] < 8'd16) begin
                int c = int'(m_sub[j][3:0]);
                if (e_old[c] && e_new[c]) begin
                    for (int i = 0; i < NE; i++) begin
                        if (ev[i] && m_pub[i][31] && m_pub[i][7:0] == m_sub[j][7:0])
                            r[j] = 1'b1;
                    end
                end
            end
        end
        return r;
    endfunction

    // Driver: one cycle of stimulus, expected result pushed to scoreboard.
    task automatic step(input logic [NE-1:0] ev, input logic we, input logic [7:0] a,
                        input logic [31:0] d, input int req);
        logic [NC-1:0] e_new = m_en;
        sb_t it;
        if (we) begin
            if (a == 8'h00) e_new = d[NC-1:0];
            else if (a == 8'h01) e_new = m_en | d[NC-1:0];
            else if (a == 8'h02) e_new = m_en & ~d[NC-1:0];
        end
        it.due = cyc + 1;
        it.exp = model(ev, m_en, e_new);
        it.req = req;
        sb.push_back(it);
        evt_i = ev; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        if (we) begin
            for (int i = 0; i < NE; i++) if (a == 8'(8'h10 + i)) m_pub[i] = d;
            for (int j = 0; j < NT; j++) if (a == 8'(8'h20 + j)) m_sub[j] = d;
        end
        m_en = e_new;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input int req);
        step('0, 1'b1, a, d, req);
    endtask

    task automatic ev_only(input logic [NE-1:0] ev, input int req);
        step(ev, 1'b0, 8'h00, 32'h0, req);
    endtask

    function automatic logic [31:0] lnk(input logic on, input logic [7:0] ch);
        return {on, 23'h0, ch};
    endfunction

    // Monitor: compare outputs against due scoreboard entries.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            sb_t it;
            it = sb.pop_front();
            n_chk++;
            if (task_o !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d cyc=%0d task_o actual=%b expected=%b",
                         it.req, cyc, task_o, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R0 watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) m_pub[i] = '0;
        for (int j = 0; j < NT; j++) m_sub[j] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs zero while in reset
        n_chk++;
        if (task_o !== '0) begin
            n_fail++;
            $display("FAIL R1 reset task_o actual=%b expected=%b", task_o, 4'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no routing after reset
        ev_only(4'b1111, 1);
        // R1: links set but channels still disabled
        wr(8'h10, lnk(1, 8'd3), 1);
        wr(8'h20, lnk(1, 8'd3), 1);
        ev_only(4'b0001, 1);
        // R9: set enables ch3, then R2 latency and single pulse
        wr(8'h01, 32'h0000_0008, 9);
        ev_only(4'b0001, 2);
        ev_only(4'b0000, 2);
        // R3: fan-out to sinks 1,2
        wr(8'h21, lnk(1, 8'd3), 3);
        wr(8'h22, lnk(1, 8'd3), 3);
        ev_only(4'b0001, 3);
        ev_only(4'b0000, 3);
        // R4: OR merge of sources 0 and 1
        wr(8'h11, lnk(1, 8'd3), 4);
        ev_only(4'b0011, 4);
        ev_only(4'b0001, 4);
        ev_only(4'b0010, 4);
        ev_only(4'b0000, 4);
        // R8: whole-mask write enables ch3 and ch5; R3 parallel channels
        wr(8'h12, lnk(1, 8'd5), 8);
        wr(8'h23, lnk(1, 8'd5), 8);
        wr(8'h00, 32'h0000_0028, 8);
        ev_only(4'b0100, 3);
        ev_only(4'b0101, 3);
        // R10: clear ch5 in same cycle as event -> dropped
        step(4'b0100, 1'b1, 8'h02, 32'h0000_0020, 10);
        // R5/R9: ch5 cleared, event blocked
        ev_only(4'b0100, 5);
        // R10: set ch5 in same cycle as event -> dropped
        step(4'b0100, 1'b1, 8'h01, 32'h0000_0020, 10);
        ev_only(4'b0100, 2);
        // R8: zero writes to set and clear change nothing
        step(4'b0000, 1'b1, 8'h01, 32'h0, 8);
        step(4'b0100, 1'b1, 8'h02, 32'h0, 8);
        ev_only(4'b0101, 8);
        // R6: sink link off
        wr(8'h23, lnk(0, 8'd5), 6);
        ev_only(4'b0100, 6);
        // R6: source link off
        wr(8'h23, lnk(1, 8'd5), 6);
        wr(8'h12, lnk(0, 8'd5), 6);
        ev_only(4'b0100, 6);
        // R7: channel 19 and 131 reach nothing even with all enabled
        wr(8'h00, 32'h0000_FFFF, 7);
        wr(8'h13, lnk(1, 8'd19), 7);
        wr(8'h23, lnk(1, 8'd19), 7);
        ev_only(4'b1000, 7);
        wr(8'h13, lnk(1, 8'd131), 7);
        wr(8'h23, lnk(1, 8'd131), 7);
        ev_only(4'b1000, 7);
        // R7: channel 15 works
        wr(8'h13, lnk(1, 8'd15), 7);
        wr(8'h23, lnk(1, 8'd15), 7);
        ev_only(4'b1000, 7);
        ev_only(4'b1001, 7);
        // R5: disable ch15 via whole mask, then event blocked
        wr(8'h00, 32'h0000_7FFF, 5);
        ev_only(4'b1000, 5);
        ev_only(4'b0000, 5);
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2 scoreboard left actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule